// File: doc/BRIEF.md
# Periodic Tick Timer with Self-Reloading Comparator

This block keeps a 64-bit count that rises by one every clock while it is running. It compares the count against a 64-bit compare value and raises a one-cycle interrupt pulse each time the count catches up with that value. It is meant to produce the periodic scheduler tick of a system. Software reaches it through a small 32-bit register bus. The bus has one address, a write strobe and write data, and read data returns combinationally for the address being presented.

The reload mode is what makes the tick periodic. When it is on, every match adds a programmable step to the compare value, so the next match falls one step later and software never has to rewrite the comparator. Software reads the count as two live halves with no snapshot. It reads the upper half, then the lower half, then the upper half again, and it retries when the two upper reads disagree. The width of a half is a parameter; it is 32 by default.

Register offsets (word index on `bus_addr`):

| Offset | Name | Access | Content |
|---|---|---|---|
| 0 | count low | read-only | lower half of the count |
| 1 | count high | read-only | upper half of the count |
| 2 | control | read/write | bit0 run, bit1 compare enable, bit2 interrupt enable, bit3 auto-reload enable |
| 3 | status | read / write-1-to-clear | bit0 pending flag |
| 4 | compare low | read/write | lower half of the compare value |
| 5 | compare high | read/write | upper half of the compare value |
| 6 | step | read/write | value added to the compare value on each match when reloading |
| 7 | none | read-only | reads 0 |

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset every register reads 0, including offset 7, and `irq_pulse` is low.
- R2: Writes to offsets 0, 1 and 7 change nothing; the count and the read value of offset 7 are unaffected.
- R3: While control bit0 (run) is 1, the count rises by exactly one per clock; while it is 0, the count holds. Offset 0 returns the lower half and offset 1 the upper half.
- R4: While control bit1 (compare enable) is 0, no match is detected and the pending flag is not set, whatever the compare value. The compare halves are written at offsets 4 and 5 and read back there.
- R5: A match occurs when compare enable is 1 and count >= compare value, including a compare value that the count has already passed. In the clock after the match, status bit0 (pending) becomes 1.
- R6: Each match event gives exactly one `irq_pulse`, one clock wide, in the clock after the match. A match condition that persists without a reload gives no further pulse until the condition has gone false and become true again.
- R7: A write to offset 3 with bit0 = 1 clears pending; with bit0 = 0 it has no effect. A match in the same clock as a clearing write leaves pending set.
- R8: Control bit2 (interrupt enable) gates `irq_pulse` only; with it at 0 a match still sets pending.
- R9: With control bit3 (auto-reload) at 1, each match adds the step register (offset 6) to the compare value and re-arms detection, so a running count gives one pulse every step clocks. With bit3 at 0 the compare value is left unchanged.
- R10: The count halves are read live. A high-low-high read with a retry on a mismatch yields the exact count at the time of the low read, even when a carry out of the lower half falls inside the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_addr | input | 3 | register offset |
| bus_wr | input | 1 | write strobe, one write per clock it is high |
| bus_wdata | input | BUS_W | write data |
| bus_rdata | output | BUS_W | read data for `bus_addr`, combinational |
| irq_pulse | output | 1 | one-clock interrupt pulse per match event |

## Verification
The bench first enables comparison with a compare value the count has already passed. A design that tested for equality would never fire, and one that drove a level would pulse on every clock. It then programs a compare value while comparison is off, and checks that a status write of zero leaves the flag set while a write of one clears it. With interrupts masked, it checks that the flag still rises and no pulse appears. It drives the reload mode across three periods and reads back the advanced compare value, which exposes a missing re-arm or a wrong addend. Finally, a bench built with narrow halves times a high-low-high read so that it straddles a carry, which catches halves that are latched or swapped.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
package tick_timer_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_CNT_LO = 3'd0,
        SEL_CNT_HI = 3'd1,
        SEL_CTRL   = 3'd2,
        SEL_STAT   = 3'd3,
        SEL_CMP_LO = 3'd4,
        SEL_CMP_HI = 3'd5,
        SEL_STEP   = 3'd6,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    // bit0 run, bit1 compare enable, bit2 interrupt enable, bit3 auto-reload
    typedef struct packed {
        logic auto_en;
        logic irq_en;
        logic cmp_en;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int NHALF  = 2;

    function automatic reg_sel_e decode_sel(input logic [SEL_W-1:0] a);
        return reg_sel_e'(a);
    endfunction

endpackage

// File: rtl/tick_counter.sv
`timescale 1ns/1ps
module tick_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/tick_compare.sv
`timescale 1ns/1ps
module tick_compare
    import tick_timer_pkg::*;
#(
    parameter int HALF_W = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NHALF*HALF_W-1:0]    cnt,
    input  ctrl_t                      ctrl,
    input  logic [HALF_W-1:0]          step,
    input  logic [NHALF-1:0]           cmp_wr,
    input  logic [HALF_W-1:0]          wr_half,
    input  logic                       stat_clr,
    output logic [NHALF*HALF_W-1:0]    cmp_val,
    output logic                       pending,
    output logic                       irq_pulse
);

    localparam int CW = NHALF * HALF_W;

    logic [CW-1:0] cmp_q;
    logic [CW-1:0] cmp_d;
    logic [CW-1:0] cmp_sum;
    logic          match_now;
    logic          seen_q;
    logic          hit;
    logic          reload;

    assign match_now = ctrl.cmp_en && (cnt >= cmp_q);
    assign hit       = match_now && !seen_q;
    assign reload    = hit && ctrl.auto_en;
    assign cmp_sum   = cmp_q + CW'(step);

    // a software write to a half takes priority over the reload of that half
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        assign cmp_d[h*HALF_W +: HALF_W] =
            cmp_wr[h] ? wr_half :
            reload    ? cmp_sum[h*HALF_W +: HALF_W] :
                        cmp_q[h*HALF_W +: HALF_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q     <= '0;
            seen_q    <= 1'b0;
            pending   <= 1'b0;
            irq_pulse <= 1'b0;
        end else begin
            cmp_q     <= cmp_d;
            // a reload re-arms detection so the next period can fire again
            seen_q    <= match_now && !reload;
            irq_pulse <= hit && ctrl.irq_en;
            if (hit) begin
                pending <= 1'b1;
            end else if (stat_clr) begin
                pending <= 1'b0;
            end
        end
    end

    assign cmp_val = cmp_q;

endmodule

// File: rtl/tick_regs.sv
`timescale 1ns/1ps
module tick_regs
    import tick_timer_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int BUS_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [SEL_W-1:0]        bus_addr,
    input  logic                    bus_wr,
    input  logic [BUS_W-1:0]        bus_wdata,
    input  logic [NHALF*HALF_W-1:0] cnt_val,
    input  logic [NHALF*HALF_W-1:0] cmp_val,
    input  logic                    pending,
    output ctrl_t                   ctrl,
    output logic [HALF_W-1:0]       step,
    output logic [NHALF-1:0]        cmp_wr,
    output logic [HALF_W-1:0]       wr_half,
    output logic                    stat_clr,
    output logic [BUS_W-1:0]        bus_rdata
);

    reg_sel_e sel;

    assign sel      = decode_sel(bus_addr);
    assign wr_half  = bus_wdata[HALF_W-1:0];
    assign cmp_wr   = {bus_wr && (sel == SEL_CMP_HI), bus_wr && (sel == SEL_CMP_LO)};
    assign stat_clr = bus_wr && (sel == SEL_STAT) && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            step <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_CTRL: ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
                SEL_STEP: step <= bus_wdata[HALF_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CNT_LO: bus_rdata = BUS_W'(cnt_val[HALF_W-1:0]);
            SEL_CNT_HI: bus_rdata = BUS_W'(cnt_val[NHALF*HALF_W-1:HALF_W]);
            SEL_CTRL:   bus_rdata = BUS_W'(ctrl);
            SEL_STAT:   bus_rdata = BUS_W'(pending);
            SEL_CMP_LO: bus_rdata = BUS_W'(cmp_val[HALF_W-1:0]);
            SEL_CMP_HI: bus_rdata = BUS_W'(cmp_val[NHALF*HALF_W-1:HALF_W]);
            SEL_STEP:   bus_rdata = BUS_W'(step);
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int BUS_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             irq_pulse
);

    localparam int CW = NHALF * HALF_W;

    ctrl_t             ctrl_q;
    logic [HALF_W-1:0] step_q;
    logic [NHALF-1:0]  cmp_wr;
    logic [HALF_W-1:0] wr_half;
    logic              stat_clr;
    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     cmp_q;
    logic              pend_q;

    tick_regs #(.HALF_W(HALF_W), .BUS_W(BUS_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .cnt_val   (cnt_q),
        .cmp_val   (cmp_q),
        .pending   (pend_q),
        .ctrl      (ctrl_q),
        .step      (step_q),
        .cmp_wr    (cmp_wr),
        .wr_half   (wr_half),
        .stat_clr  (stat_clr),
        .bus_rdata (bus_rdata)
    );

    tick_counter #(.CNT_W(CW)) cnt_i (
        .clk (clk),
        .rst (rst),
        .run (ctrl_q.run),
        .cnt (cnt_q)
    );

    tick_compare #(.HALF_W(HALF_W)) cmp_i (
        .clk       (clk),
        .rst       (rst),
        .cnt       (cnt_q),
        .ctrl      (ctrl_q),
        .step      (step_q),
        .cmp_wr    (cmp_wr),
        .wr_half   (wr_half),
        .stat_clr  (stat_clr),
        .cmp_val   (cmp_q),
        .pending   (pend_q),
        .irq_pulse (irq_pulse)
    );

endmodule

// File: rtl/tick_timer_chk.sv
`timescale 1ns/1ps
module tick_timer_chk
    import tick_timer_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int BUS_W  = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic [2:0]              bus_addr,
    input logic                    bus_wr,
    input logic [BUS_W-1:0]        bus_wdata,
    input logic                    irq_pulse,
    input ctrl_t                   ctrl,
    input logic [NHALF*HALF_W-1:0] cnt_val,
    input logic                    pending
);

    logic clr_req;
    assign clr_req = bus_wr && (bus_addr == 3'd3) && bus_wdata[0];

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (cnt_val == '0) && !pending && !irq_pulse);  // R1

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        ctrl.run |=> cnt_val == $past(cnt_val) + 1'b1);  // R3

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |=> $stable(cnt_val));  // R3

    AST_SET_NEEDS_CMP: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(ctrl.cmp_en));  // R4

    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> pending);  // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        pending && !clr_req |=> pending);  // R7

    AST_PULSE_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> $past(ctrl.irq_en));  // R8

endmodule

bind tick_timer tick_timer_chk #(.HALF_W(HALF_W), .BUS_W(BUS_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .irq_pulse (irq_pulse),
    .ctrl      (ctrl_q),
    .cnt_val   (cnt_q),
    .pending   (pend_q)
);

// File: tb/tick_timer_tb_top.sv
`timescale 1ns/1ps
module tick_timer_tb_top;

    localparam int HW = 10;
    localparam int BW = 32;
    localparam int CW = 2 * HW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [BW-1:0] bus_wdata = '0;
    logic [BW-1:0] bus_rdata;
    logic          irq_pulse;

    always #2 clk = ~clk;  // 250 MHz

    tick_timer #(.HALF_W(HW), .BUS_W(BW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_pulse (irq_pulse)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // reference count: follows the run bit as the bus writes it
    logic [CW-1:0] ref_cnt;
    bit            ref_run;
    always @(posedge clk) begin
        if (rst) begin
            ref_cnt <= '0;
            ref_run <= 1'b0;
        end else begin
            if (ref_run) ref_cnt <= ref_cnt + 1'b1;
            if (bus_wr && bus_addr == 3'd2) ref_run <= bus_wdata[0];
        end
    end

    // scoreboard: reference count expected at each pulse
    logic [CW-1:0] exp_q[$];

    task automatic check(input string tag, input longint act, input longint exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && irq_pulse) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected irq pulse", 1, 0);
            end else begin
                logic [CW-1:0] e;
                e = exp_q.pop_front();
                check("R6 R9 pulse timing", longint'(ref_cnt), longint'(e));
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [BW-1:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [BW-1:0] d, output logic [CW-1:0] snap);
        bus_addr = a;
        #1;
        d    = bus_rdata;
        snap = ref_cnt;
        @(negedge clk);
    endtask

    task automatic wait_cnt(input logic [CW-1:0] v);
        while (ref_cnt < v) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        logic [BW-1:0] d;
        logic [BW-1:0] h1;
        logic [BW-1:0] h2;
        logic [BW-1:0] lo;
        logic [CW-1:0] s;
        logic [CW-1:0] s_lo;
        logic [CW-1:0] base;
        logic [CW-1:0] c;
        int retries;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], d, s);
            check("R1 reset register value", d, 0);
        end
        check("R1 irq idle after reset", irq_pulse, 0);

        // R2 read-only offsets
        wr(3'd0, 32'h3ff);
        wr(3'd1, 32'h2a5);
        wr(3'd7, 32'hffff_ffff);
        rd(3'd0, d, s);
        check("R2 count low write ignored", d, 0);
        rd(3'd1, d, s);
        check("R2 count high write ignored", d, 0);
        rd(3'd7, d, s);
        check("R2 offset 7 reads zero", d, 0);

        // R3 run and hold
        wr(3'd2, 32'h1);
        repeat (9) @(negedge clk);
        rd(3'd0, d, s);
        check("R3 count while running", d, longint'(s[HW-1:0]));
        check("R3 count advanced", (s > 0) ? 1 : 0, 1);
        wr(3'd2, 32'h0);
        rd(3'd0, d, s);
        repeat (6) @(negedge clk);
        rd(3'd0, h1, s);
        check("R3 count holds when stopped", h1, d);
        check("R3 held count value", h1, longint'(s[HW-1:0]));

        // R4 comparator written with compare disabled
        base = ref_cnt;
        wr(3'd4, 32'h3);
        wr(3'd5, 32'h0);
        rd(3'd4, d, s);
        check("R4 compare low readback", d, 3);
        rd(3'd5, d, s);
        check("R4 compare high readback", d, 0);
        wr(3'd2, 32'hC);
        repeat (5) @(negedge clk);
        rd(3'd3, d, s);
        check("R4 no flag while compare disabled", d, 0);

        // R5 R6 comparator already passed, single pulse
        exp_q.push_back(base);
        wr(3'd2, 32'h6);
        repeat (8) @(negedge clk);
        rd(3'd3, d, s);
        check("R5 pending after passed compare value", d, 1);
        check("R6 expected pulse seen", exp_q.size(), 0);
        rd(3'd4, d, s);
        check("R6 compare unchanged without reload", d, 3);

        // R7 write-1-to-clear
        wr(3'd3, 32'h0);
        rd(3'd3, d, s);
        check("R7 writing zero keeps pending", d, 1);
        wr(3'd3, 32'h1);
        rd(3'd3, d, s);
        check("R7 writing one clears pending", d, 0);
        repeat (5) @(negedge clk);
        rd(3'd3, d, s);
        check("R6 persistent match does not re-fire", d, 0);

        // R8 interrupt masked, flag still set
        wr(3'd2, 32'h0);
        c = ref_cnt + 30;
        wr(3'd4, BW'(c[HW-1:0]));
        wr(3'd5, BW'(c[CW-1:HW]));
        wr(3'd2, 32'h3);
        wait_cnt(c + 5);
        rd(3'd3, d, s);
        check("R8 pending set with interrupt masked", d, 1);
        wr(3'd3, 32'h1);

        // R9 auto-reload periodic pulses
        wr(3'd2, 32'h1);
        c = ref_cnt + 40;
        wr(3'd4, BW'(c[HW-1:0]));
        wr(3'd5, BW'(c[CW-1:HW]));
        wr(3'd6, 32'd20);
        exp_q.push_back(c + 1);
        exp_q.push_back(c + 21);
        exp_q.push_back(c + 41);
        wr(3'd2, 32'hF);
        wait_cnt(c + 50);
        wr(3'd2, 32'h1);
        rd(3'd4, d, s);
        rd(3'd5, h1, s);
        check("R9 compare advanced by three steps", {h1[HW-1:0], d[HW-1:0]}, longint'(c + 60));
        check("R9 three periodic pulses seen", exp_q.size(), 0);

        // R10 high-low-high read across a carry out of the low half
        retries = 0;
        wait_cnt(CW'(1022));
        for (int i = 0; i < 4; i++) begin
            rd(3'd1, h1, s);
            rd(3'd0, lo, s_lo);
            rd(3'd1, h2, s);
            if (h1 != h2) begin
                retries++;
            end else begin
                check("R10 consistent count read", {h1[HW-1:0], lo[HW-1:0]}, longint'(s_lo));
            end
        end
        check("R10 carry forced exactly one retry", retries, 1);

        repeat (20) @(negedge clk);
        check("R6 no pulse left outstanding", exp_q.size(), 0);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule